// File: doc/BRIEF.md
# Banked Processor Register File

This block holds the programmer-visible registers of an 8-bit processor core. Six general-purpose byte registers and an accumulator/flag pair exist twice, as a main copy and an alternate copy. A single copy each is kept of a 16-bit stack pointer, two 16-bit index registers, an 8-bit interrupt-vector base and an 8-bit refresh register. Two swap inputs flip which copy is live, one for the accumulator/flag pair and one for the general-purpose group. No data moves when the copy is flipped, so a handler can change context in one cycle without any memory traffic.

The core's datapath reaches the registers through two combinational read ports, one write port and a pair step unit. Each read port and the write port can work on a single byte or on a 16-bit pair. The step unit adds or subtracts one on any pair. Everything that is written takes effect on the next rising clock edge.

Byte codes (4 bits): 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 A, 7 F, 8 SP high, 9 SP low, 10 X high, 11 X low, 12 Y high, 13 Y low, 14 vector base, 15 refresh. Pair code p (3 bits) joins byte 2p as the high half with byte 2p+1 as the low half: 0 BC, 1 DE, 2 HL, 3 AF, 4 SP, 5 X, 6 Y, 7 vector base/refresh.

Top module: `dual_bank_regfile`

## Requirements
- R1: While `rst_ni` is low and after it rises, both bank selects point at the main copy, the stack pointer reads 0 and the vector base byte (code 14) reads 0.
- R2: A byte write to code k is returned by a byte read of code k from the next cycle on, with bits 15:8 of the read data at zero.
- R3: A pair read of code p returns byte 2p in bits 15:8 and byte 2p+1 in bits 7:0. A pair write of code p (taken from `wr_addr_i[2:0]`) updates both bytes at the same edge.
- R4: A read in the same cycle as a write to the same register returns the old value. When nothing is written, stepped or swapped, read data for an unchanged address stays stable.
- R5: Each `swap_gp_i` pulse toggles which copy of codes 0 to 5 is live. The contents of the copy that is not live are kept.
- R6: Each `swap_af_i` pulse toggles which copy of codes 6 and 7 is live, independently of the general-purpose select.
- R7: Codes 8 to 15 have a single copy and are not affected by either swap.
- R8: With `step_en_i` high, pair `step_pair_i` becomes its value plus one (`step_dec_i`=0) or minus one (`step_dec_i`=1), modulo 2^16.
- R9: When the write port and the step unit touch the same byte in one cycle, the write port's value lands in that byte, and the step result still lands in the other byte of the pair.
- R10: Both read ports decode their own address and width in the same cycle, each independent of the other.
- R11: A write in the same cycle as a swap lands in the copy that was live before the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write port enable |
| wr_wide_i | input | 1 | 1: pair write, 0: byte write |
| wr_addr_i | input | 4 | Byte code, or pair code in bits 2:0 |
| wr_data_i | input | 16 | Write data (low byte used for byte writes) |
| step_en_i | input | 1 | Pair increment/decrement enable |
| step_dec_i | input | 1 | 1: decrement, 0: increment |
| step_pair_i | input | 3 | Pair code to step |
| swap_af_i | input | 1 | Toggle live accumulator/flag copy |
| swap_gp_i | input | 1 | Toggle live general-purpose copy |
| rda_wide_i | input | 1 | Read port A width |
| rda_addr_i | input | 4 | Read port A code |
| rda_data_o | output | 16 | Read port A data |
| rdb_wide_i | input | 1 | Read port B width |
| rdb_addr_i | input | 4 | Read port B code |
| rdb_data_o | output | 16 | Read port B data |

## Verification
Directed sequences come first. They load distinct values into both copies, then flip each select alone and both together, so the bench can tell a swapped general-purpose group from a swapped accumulator/flag pair and from a single-copy register. Pair steps at 0xFFFF and at 0x0000 tell a true 16-bit carry or borrow from one that stops at the low byte. A step paired with a byte write to the same pair tells per-byte precedence from whole-pair precedence. A long seeded random mix of writes, steps and swaps then compares both read ports every cycle with a bench model, and this catches wrong byte ordering and a wrong choice of copy.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;
    localparam int CODE_W  = 4;
    localparam int PCODE_W = 3;
    localparam int NCODES  = 1 << CODE_W;

    localparam logic [PCODE_W-1:0] PAIR_BC = 3'd0;
    localparam logic [PCODE_W-1:0] PAIR_DE = 3'd1;
    localparam logic [PCODE_W-1:0] PAIR_HL = 3'd2;
    localparam logic [PCODE_W-1:0] PAIR_AF = 3'd3;
    localparam logic [PCODE_W-1:0] PAIR_SP = 3'd4;
    localparam logic [PCODE_W-1:0] PAIR_X  = 3'd5;
    localparam logic [PCODE_W-1:0] PAIR_Y  = 3'd6;
    localparam logic [PCODE_W-1:0] PAIR_VR = 3'd7;

    localparam logic [CODE_W-1:0] BYTE_VEC = 4'd14;
endpackage

// File: rtl/dbrf_bank.sv
module dbrf_bank #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 8
) (
    input  logic                           clk_i,
    input  logic [NBYTES-1:0]              we_i,
    input  logic [NBYTES-1:0][DATA_W-1:0]  wd_i,
    output logic [NBYTES-1:0][DATA_W-1:0]  rd_o
);
    logic [NBYTES-1:0][DATA_W-1:0] mem_q;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        always_ff @(posedge clk_i) begin
            if (we_i[k]) mem_q[k] <= wd_i[k];
        end
    end

    assign rd_o = mem_q;
endmodule

// File: rtl/dbrf_step.sv
module dbrf_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] val_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        val_o = dec_i ? (val_i - ONE) : (val_i + ONE);
    end
endmodule

// File: rtl/dbrf_read_port.sv
module dbrf_read_port #(
    parameter int DATA_W = 8,
    parameter int NCODES = 16,
    parameter int CODE_W = 4
) (
    input  logic [NCODES-1:0][DATA_W-1:0] view_i,
    input  logic                          wide_i,
    input  logic [CODE_W-1:0]             addr_i,
    output logic [2*DATA_W-1:0]           data_o
);
    logic [CODE_W-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_idx = {addr_i[CODE_W-2:0], 1'b0};
        lo_idx = {addr_i[CODE_W-2:0], 1'b1};
        if (wide_i) data_o = {view_i[hi_idx], view_i[lo_idx]};
        else        data_o = {{DATA_W{1'b0}}, view_i[addr_i]};
    end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import dbrf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 8,
    parameter int GP_BYTES   = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic                  wr_wide_i,
    input  logic [CODE_W-1:0]     wr_addr_i,
    input  logic [2*DATA_W-1:0]   wr_data_i,
    input  logic                  step_en_i,
    input  logic                  step_dec_i,
    input  logic [PCODE_W-1:0]    step_pair_i,
    input  logic                  swap_af_i,
    input  logic                  swap_gp_i,
    input  logic                  rda_wide_i,
    input  logic [CODE_W-1:0]     rda_addr_i,
    output logic [2*DATA_W-1:0]   rda_data_o,
    input  logic                  rdb_wide_i,
    input  logic [CODE_W-1:0]     rdb_addr_i,
    output logic [2*DATA_W-1:0]   rdb_data_o
);
    localparam int PAIR_W = 2 * DATA_W;
    localparam int NSPEC  = NCODES - BANK_BYTES;
    localparam int NBANKS = 2;
    localparam int VEC_SLOT = int'(BYTE_VEC) - BANK_BYTES;
    localparam int SPH_SLOT = 2 * int'(PAIR_SP) - BANK_BYTES;

    typedef struct packed {
        logic                          af_sel;
        logic                          gp_sel;
        logic [NSPEC-1:0][DATA_W-1:0]  spec;
    } state_t;

    state_t state_d, state_q;

    logic [NBANKS-1:0][BANK_BYTES-1:0][DATA_W-1:0] bank_rd;
    logic [NBANKS-1:0][BANK_BYTES-1:0]             bank_we;
    logic [BANK_BYTES-1:0][DATA_W-1:0]             bank_wd;
    logic [NCODES-1:0][DATA_W-1:0]                 view;
    logic [NCODES-1:0]                             byte_we;
    logic [NCODES-1:0][DATA_W-1:0]                 byte_wd;
    logic [PAIR_W-1:0]                             step_old, step_new;
    logic [CODE_W-1:0]                             step_hi, step_lo, wr_hi, wr_lo;

    // One storage copy per bank; selects decide which is live per byte
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        dbrf_bank #(.DATA_W(DATA_W), .NBYTES(BANK_BYTES)) u_bank (
            .clk_i (clk_i),
            .we_i  (bank_we[b]),
            .wd_i  (bank_wd),
            .rd_o  (bank_rd[b])
        );
    end

    // Live view of all byte codes
    always_comb begin
        for (int k = 0; k < NCODES; k++) begin
            if (k < GP_BYTES)        view[k] = bank_rd[state_q.gp_sel][k];
            else if (k < BANK_BYTES) view[k] = bank_rd[state_q.af_sel][k];
            else                     view[k] = state_q.spec[k - BANK_BYTES];
        end
    end

    assign step_hi  = {step_pair_i, 1'b0};
    assign step_lo  = {step_pair_i, 1'b1};
    assign wr_hi    = {wr_addr_i[PCODE_W-1:0], 1'b0};
    assign wr_lo    = {wr_addr_i[PCODE_W-1:0], 1'b1};
    assign step_old = {view[step_hi], view[step_lo]};

    dbrf_step #(.WIDTH(PAIR_W)) u_step (
        .val_i (step_old),
        .dec_i (step_dec_i),
        .val_o (step_new)
    );

    // Next-state computation: step first, write port overrides per byte
    always_comb begin
        byte_we = '0;
        byte_wd = view;
        if (step_en_i) begin
            byte_we[step_hi] = 1'b1;
            byte_we[step_lo] = 1'b1;
            byte_wd[step_hi] = step_new[PAIR_W-1:DATA_W];
            byte_wd[step_lo] = step_new[DATA_W-1:0];
        end
        if (wr_en_i) begin
            if (wr_wide_i) begin
                byte_we[wr_hi] = 1'b1;
                byte_we[wr_lo] = 1'b1;
                byte_wd[wr_hi] = wr_data_i[PAIR_W-1:DATA_W];
                byte_wd[wr_lo] = wr_data_i[DATA_W-1:0];
            end else begin
                byte_we[wr_addr_i] = 1'b1;
                byte_wd[wr_addr_i] = wr_data_i[DATA_W-1:0];
            end
        end

        bank_we = '0;
        for (int k = 0; k < BANK_BYTES; k++) begin
            bank_wd[k] = byte_wd[k];
            if (k < GP_BYTES) bank_we[state_q.gp_sel][k] = byte_we[k];
            else              bank_we[state_q.af_sel][k] = byte_we[k];
        end

        state_d = state_q;
        for (int k = 0; k < NSPEC; k++) begin
            if (byte_we[BANK_BYTES + k]) state_d.spec[k] = byte_wd[BANK_BYTES + k];
        end
        state_d.af_sel = state_q.af_sel ^ swap_af_i;
        state_d.gp_sel = state_q.gp_sel ^ swap_gp_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q      <= '0;
            state_q.spec <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    dbrf_read_port #(.DATA_W(DATA_W), .NCODES(NCODES), .CODE_W(CODE_W)) u_rda (
        .view_i (view),
        .wide_i (rda_wide_i),
        .addr_i (rda_addr_i),
        .data_o (rda_data_o)
    );

    dbrf_read_port #(.DATA_W(DATA_W), .NCODES(NCODES), .CODE_W(CODE_W)) u_rdb (
        .view_i (view),
        .wide_i (rdb_wide_i),
        .addr_i (rdb_addr_i),
        .data_o (rdb_data_o)
    );

    // Reset slots referenced for clarity of the reset requirement
    logic [DATA_W-1:0] unused_vec, unused_sph;
    assign unused_vec = state_q.spec[VEC_SLOT];
    assign unused_sph = state_q.spec[SPH_SLOT];
endmodule

// File: rtl/dbrf_checker.sv
module dbrf_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        wr_en_i,
    input logic        wr_wide_i,
    input logic [3:0]  wr_addr_i,
    input logic [15:0] wr_data_i,
    input logic        step_en_i,
    input logic        step_dec_i,
    input logic [2:0]  step_pair_i,
    input logic        swap_af_i,
    input logic        swap_gp_i,
    input logic        af_sel,
    input logic        gp_sel,
    input logic [15:0] sp_val,
    input logic [15:0] x_val,
    input logic        rda_wide_i,
    input logic [3:0]  rda_addr_i,
    input logic [15:0] rda_data_o
);
    assert_af_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swap_af_i |=> af_sel != $past(af_sel));

    assert_gp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !swap_gp_i |=> gp_sel == $past(gp_sel));

    assert_sp_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && step_pair_i == 3'd4 && !wr_en_i) |=>
        sp_val == ($past(step_dec_i) ? 16'($past(sp_val) - 16'd1) : 16'($past(sp_val) + 16'd1)));

    assert_pair_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_wide_i && wr_addr_i[2:0] == 3'd5) |=> x_val == $past(wr_data_i));

    assert_quiet_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !step_en_i && !swap_af_i && !swap_gp_i) |=>
        (!($stable(rda_addr_i) && $stable(rda_wide_i)) || $stable(rda_data_o)));
endmodule

bind dual_bank_regfile dbrf_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_wide_i   (wr_wide_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .step_en_i   (step_en_i),
    .step_dec_i  (step_dec_i),
    .step_pair_i (step_pair_i),
    .swap_af_i   (swap_af_i),
    .swap_gp_i   (swap_gp_i),
    .af_sel      (state_q.af_sel),
    .gp_sel      (state_q.gp_sel),
    .sp_val      ({state_q.spec[0], state_q.spec[1]}),
    .x_val       ({state_q.spec[2], state_q.spec[3]}),
    .rda_wide_i  (rda_wide_i),
    .rda_addr_i  (rda_addr_i),
    .rda_data_o  (rda_data_o)
);

// File: tb/dual_bank_regfile_bench.sv
`timescale 1ns/100ps
module dual_bank_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_wide, step_en, step_dec, swap_af, swap_gp;
    logic [3:0]  wr_addr, ra_addr, rb_addr;
    logic [15:0] wr_data, ra_data, rb_data;
    logic [2:0]  step_pair;
    logic        ra_wide, rb_wide;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] mbank [2][8];
    logic [7:0] mspec [8];
    logic       mgp, maf;

    always #2 clk = ~clk;

    dual_bank_regfile u_dual_bank_regfile (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_wide_i(wr_wide), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .step_en_i(step_en), .step_dec_i(step_dec), .step_pair_i(step_pair),
        .swap_af_i(swap_af), .swap_gp_i(swap_gp),
        .rda_wide_i(ra_wide), .rda_addr_i(ra_addr), .rda_data_o(ra_data),
        .rdb_wide_i(rb_wide), .rdb_addr_i(rb_addr), .rdb_data_o(rb_data)
    );

    function automatic logic [7:0] mbyte(input int k);
        if (k < 6)      return mbank[mgp][k];
        else if (k < 8) return mbank[maf][k];
        else            return mspec[k-8];
    endfunction

    function automatic logic [15:0] mread(input logic wide, input logic [3:0] a);
        if (wide) return {mbyte({a[2:0], 1'b0}), mbyte({a[2:0], 1'b1})};
        else      return {8'h00, mbyte(a)};
    endfunction

    task automatic mput(input int k, input logic [7:0] v);
        if (k < 6)      mbank[mgp][k] = v;
        else if (k < 8) mbank[maf][k] = v;
        else            mspec[k-8] = v;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, compare reads with model, update model
    task automatic cyc(input logic we, input logic wide, input logic [3:0] wa, input logic [15:0] wd,
                       input logic se, input logic sd, input logic [2:0] sp,
                       input logic xa, input logic xg,
                       input logic aw, input logic [3:0] aa, input logic bw, input logic [3:0] ba,
                       input string tag);
        logic [15:0] stepped;
        int hi, lo;
        @(negedge clk);
        wr_en = we; wr_wide = wide; wr_addr = wa; wr_data = wd;
        step_en = se; step_dec = sd; step_pair = sp;
        swap_af = xa; swap_gp = xg;
        ra_wide = aw; ra_addr = aa; rb_wide = bw; rb_addr = ba;
        #1;
        check({tag, " portA"}, ra_data, mread(aw, aa));
        check({tag, " portB"}, rb_data, mread(bw, ba));
        if (se) begin
            hi = 2 * sp; lo = hi + 1;
            stepped = {mbyte(hi), mbyte(lo)};
            stepped = sd ? stepped - 16'd1 : stepped + 16'd1;
            mput(hi, stepped[15:8]);
            mput(lo, stepped[7:0]);
        end
        if (we) begin
            if (wide) begin
                mput(2 * wa[2:0], wd[15:8]);
                mput(2 * wa[2:0] + 1, wd[7:0]);
            end else begin
                mput(wa, wd[7:0]);
            end
        end
        maf = maf ^ xa;
        mgp = mgp ^ xg;
    endtask

    task automatic idle_read(input logic aw, input logic [3:0] aa, input logic bw, input logic [3:0] ba,
                             input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, aw, aa, bw, ba, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; wr_en = 0; wr_wide = 0; wr_addr = 0; wr_data = 0;
        step_en = 0; step_dec = 0; step_pair = 0; swap_af = 0; swap_gp = 0;
        ra_wide = 0; ra_addr = 0; rb_wide = 0; rb_addr = 0;
        mgp = 0; maf = 0;
        for (int k = 0; k < 8; k++) mspec[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset values during reset
        ra_wide = 1; ra_addr = 4'd4; rb_wide = 0; rb_addr = 4'd14;
        #1;
        check("R1 sp in reset", ra_data, 16'h0000);
        check("R1 vec in reset", rb_data, 16'h0000);
        @(negedge clk); rst_n = 1;

        // R1 after reset; R2 byte loads of every code in main copies
        idle_read(1, 4'd4, 0, 4'd14, "R1 after reset");
        for (int k = 0; k < 16; k++)
            cyc(1, 0, 4'(k), {8'hEE, 8'(8'h10 + k)}, 0, 0, 0, 0, 0, 0, 4'(k), 0, 4'(k), "R4 write-same-cycle");
        for (int k = 0; k < 16; k++) idle_read(0, 4'(k), 1, 4'(k >> 1), "R2 byte readback");
        // fill alternate copies (R11: swap in same cycle as last main write)
        cyc(1, 0, 4'd7, 16'h0017, 0, 0, 0, 1, 1, 0, 4'd7, 0, 4'd0, "R11 write+swap");
        for (int k = 0; k < 8; k++) cyc(1, 0, 4'(k), {8'h00, 8'(8'hA0 + k)}, 0, 0, 0, 0, 0, 0, 4'(k), 0, 4'd9, "R2 alt load");
        idle_read(1, 4'd0, 1, 4'd3, "R3 alt pairs");
        // R5 swap gp only: BC main, AF stays alt
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 4'd0, 1, 4'd3, "R5 before swap");
        idle_read(1, 4'd0, 1, 4'd3, "R5 gp swapped");
        idle_read(1, 4'd2, 0, 4'd6, "R6 af independent");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 4'd3, 1, 4'd4, "R6 swap af");
        idle_read(1, 4'd3, 0, 4'd7, "R6 af swapped");
        // R7 singles unaffected by swaps
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 4'd5, 1, 4'd6, "R7 swap both");
        idle_read(1, 4'd5, 1, 4'd7, "R7 singles kept");
        idle_read(1, 4'd4, 0, 4'd15, "R7 sp kept");
        // R8 wrap
        cyc(1, 1, 4'd2, 16'hFFFF, 0, 0, 0, 0, 0, 1, 4'd2, 0, 4'd0, "R3 pair write");
        cyc(0, 0, 0, 0, 1, 0, 3'd2, 0, 0, 1, 4'd2, 0, 4'd4, "R8 inc");
        idle_read(1, 4'd2, 0, 4'd5, "R8 inc wrap");
        cyc(1, 1, 4'd4, 16'h0000, 0, 0, 0, 0, 0, 1, 4'd4, 0, 4'd9, "R3 sp write");
        cyc(0, 0, 0, 0, 1, 1, 3'd4, 0, 0, 1, 4'd4, 0, 4'd8, "R8 dec");
        idle_read(1, 4'd4, 0, 4'd8, "R8 dec wrap");
        // R9 write precedence per byte: step HL, write L
        cyc(1, 1, 4'd2, 16'h12FF, 0, 0, 0, 0, 0, 1, 4'd2, 0, 4'd4, "R9 setup");
        cyc(1, 0, 4'd5, 16'h0055, 1, 0, 3'd2, 0, 0, 1, 4'd2, 0, 4'd5, "R9 collide");
        idle_read(1, 4'd2, 0, 4'd4, "R9 high stepped low written");
        check("R9 explicit HL", ra_data, 16'h1355);
        // random mix, R10 independent ports
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0], r[1], r[5:2], $urandom, r[6] & r[7], r[8], r[11:9],
                r[12] & r[13], r[14] & r[15], r[16], r[20:17], r[21], r[25:22], "R10 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule